// File: doc/BRIEF.md
# Serial Link Deframer with Alignment Monitor

This block sits behind the clock-recovery stage of a point-to-point serial receiver. It takes the recovered line one bit per clock, looks for 40-bit frame alignment, and turns the stream back into parallel words. Each frame carries a two-bit header, a disparity-invert bit, a parity bit and a 36-bit payload. The header marks the frame as a data word, a data word that carries the sideband flag, or a stuffing frame that the transmitter sends while it has nothing to move.

Once aligned, the block delivers each data word on a 36-bit output together with its received parity bit and a one-cycle write strobe. Stuffing frames produce nothing. Each flagged word flips a level output, so the far end sees a toggle for every marker. A bad header or a parity mismatch while aligned gives a one-cycle low pulse on an active-low error output and raises the active-low link-synchronized status. The block then hunts for alignment again from the next bit.

Top module: `link_deframer`

## Requirements
- R1: While reset is held and on the first cycle after it, `link_sync_n` and `link_err_n` are 1, and `rx_flag_tgl` and `rx_wr_stb` are 0.
- R2: A frame is 40 bits and arrives MSB first. Bits 39:38 are the header: 2'b10 is a data word, 2'b11 is a data word carrying the flag, 2'b01 is stuffing and 2'b00 is invalid. Bit 37 is the invert bit, bit 36 is the parity bit and bits 35:0 are the payload.
- R3: While hunting, the 40-bit window moves one bit per cycle. `link_sync_n` goes low on the boundary of the fourth consecutive frame at one alignment that has a legal header and even parity. Before that boundary it stays high.
- R4: For an unflagged data word while synchronized, `rx_wr_stb` is high for exactly one cycle, starting two clock edges after the edge that samples the frame's last bit. In that same cycle `rx_word` takes the payload and `rx_par` takes the received parity bit.
- R5: A stuffing frame produces no strobe, and no strobe occurs while `link_sync_n` is high.
- R6: When the invert bit is 1, the payload is complemented before the parity check and before it reaches `rx_word`.
- R7: A parity mismatch (data XOR parity bit not even) in a synchronized frame drives `link_err_n` low for one cycle. In that same cycle `link_sync_n` goes high. No strobe is issued, and hunting restarts.
- R8: A header of 2'b00 in a synchronized frame behaves as in R7.
- R9: A flagged word inverts `rx_flag_tgl` in the cycle its strobe rises. That strobe comes one cycle later than R4, three edges after the last bit is sampled, so the low time before it is stretched.
- R10: Frames that fail while the block is hunting or confirming alignment are never reported on `link_err_n`.
- R11: `rx_word`, `rx_par` and `rx_flag_tgl` change only in a cycle where `rx_wr_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial line bit, one per clock |
| rx_word | output | 36 | Restored payload of the last data word |
| rx_par | output | 1 | Received parity bit of that word |
| rx_flag_tgl | output | 1 | Flips once per flagged word |
| rx_wr_stb | output | 1 | One-cycle pulse per delivered data word |
| link_err_n | output | 1 | Low for one cycle on a header or parity fault while synchronized |
| link_sync_n | output | 1 | Low while frame alignment is held |

## Verification
The bench counts clock edges. For every frame it records the edge that samples the frame's last bit. A strobe and its word are expected two edges later, or three for a flagged word. An error pulse and the loss of sync are expected two edges later. The lock decision is checked on the fourth confirming frame: sync must still be high two edges after the third frame's boundary and low two edges after the fourth. All outputs are sampled on the falling clock edge, at the exact edge count stored for each expected event. Any strobe or error pulse that was not expected, or that arrives at another count, is reported.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

  typedef enum logic [1:0] {
    LNK_HUNT  = 2'd0,
    LNK_CHECK = 2'd1,
    LNK_SYNC  = 2'd2
  } link_state_e;

  typedef enum logic [1:0] {
    HDR_BAD       = 2'b00,
    HDR_STUFF     = 2'b01,
    HDR_WORD      = 2'b10,
    HDR_WORD_FLAG = 2'b11
  } hdr_code_e;

  function automatic logic hdr_legal(input logic [1:0] h);
    return h != HDR_BAD;
  endfunction

  function automatic logic hdr_is_word(input logic [1:0] h);
    return (h == HDR_WORD) || (h == HDR_WORD_FLAG);
  endfunction

  function automatic logic hdr_has_flag(input logic [1:0] h);
    return h == HDR_WORD_FLAG;
  endfunction

endpackage

// File: rtl/deframe_window.sv
module deframe_window #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_in,
  output logic [FRAME_W-1:0] win
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= {win[FRAME_W-2:0], bit_in};
  end

endmodule

// File: rtl/deframe_decode.sv
module deframe_decode
  import deframer_pkg::*;
#(
  parameter int DATA_W  = 36,
  localparam int FRAME_W = DATA_W + 4
) (
  input  logic [FRAME_W-1:0] win,
  output logic               frame_ok,
  output logic               is_word,
  output logic               has_flag,
  output logic [DATA_W-1:0]  word,
  output logic               par_bit
);

  function automatic logic parity_even(input logic [DATA_W-1:0] w, input logic p);
    return (^{w, p}) == 1'b0;
  endfunction

  logic [1:0]        hdr;
  logic              inv;
  logic [DATA_W-1:0] raw;

  assign hdr      = win[FRAME_W-1 -: 2];
  assign inv      = win[DATA_W+1];
  assign par_bit  = win[DATA_W];
  assign raw      = win[DATA_W-1:0];
  assign word     = inv ? ~raw : raw;
  assign frame_ok = hdr_legal(hdr) && parity_even(word, par_bit);
  assign is_word  = hdr_is_word(hdr);
  assign has_flag = hdr_has_flag(hdr);

endmodule

// File: rtl/deframe_sync.sv
module deframe_sync
  import deframer_pkg::*;
#(
  parameter int FRAME_W     = 40,
  parameter int SYNC_FRAMES = 4,
  localparam int POS_W = $clog2(FRAME_W),
  localparam int CNT_W = $clog2(SYNC_FRAMES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_ok,
  output logic slot,
  output logic sync_n,
  output logic err_n
);

  link_state_e      state;
  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] cnt;
  logic             last;
  logic             fault;

  assign last  = pos == POS_W'(FRAME_W - 1);
  assign slot  = (state == LNK_SYNC) && last;
  assign fault = slot && !frame_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LNK_HUNT;
      pos    <= '0;
      cnt    <= '0;
      sync_n <= 1'b1;
      err_n  <= 1'b1;
    end else begin
      err_n <= 1'b1;
      unique case (state)
        LNK_HUNT: begin
          pos <= '0;
          if (frame_ok) begin
            state <= LNK_CHECK;
            cnt   <= CNT_W'(1);
          end
        end
        LNK_CHECK: begin
          pos <= last ? '0 : pos + POS_W'(1);
          if (last) begin
            if (!frame_ok) begin
              state <= LNK_HUNT;
            end else if (cnt == CNT_W'(SYNC_FRAMES - 1)) begin
              state  <= LNK_SYNC;
              sync_n <= 1'b0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        LNK_SYNC: begin
          pos <= last ? '0 : pos + POS_W'(1);
          if (fault) begin
            state  <= LNK_HUNT;
            sync_n <= 1'b1;
            err_n  <= 1'b0;
          end
        end
        default: state <= LNK_HUNT;
      endcase
    end
  end

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) !err_n |=> err_n); // R7
  AST_ERR_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n) !err_n |-> sync_n); // R8
  AST_LOCK_ON_GOOD_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $fell(sync_n) |-> $past(frame_ok)); // R3
  AST_ERR_ONLY_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n) $fell(err_n) |-> !$past(sync_n)); // R10

endmodule

// File: rtl/deframe_word.sv
module deframe_word #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              flag,
  input  logic [DATA_W-1:0] word,
  input  logic              par,
  output logic [DATA_W-1:0] dout,
  output logic              par_out,
  output logic              flag_out,
  output logic              wr_stb
);

  logic              pend;
  logic [DATA_W-1:0] hold_word;
  logic              hold_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      par_out   <= 1'b0;
      flag_out  <= 1'b0;
      wr_stb    <= 1'b0;
      pend      <= 1'b0;
      hold_word <= '0;
      hold_par  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      pend   <= 1'b0;
      if (pend) begin
        dout     <= hold_word;
        par_out  <= hold_par;
        flag_out <= ~flag_out;
        wr_stb   <= 1'b1;
      end
      if (take) begin
        if (flag) begin
          pend      <= 1'b1;
          hold_word <= word;
          hold_par  <= par;
        end else begin
          dout    <= word;
          par_out <= par;
          wr_stb  <= 1'b1;
        end
      end
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R4
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n) !wr_stb |-> ($stable(dout) && $stable(par_out))); // R11
  AST_FLAG_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n) !$stable(flag_out) |-> wr_stb); // R9

endmodule

// File: rtl/link_deframer.sv
module link_deframer #(
  parameter int DATA_W      = 36,
  parameter int SYNC_FRAMES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_par,
  output logic              rx_flag_tgl,
  output logic              rx_wr_stb,
  output logic              link_err_n,
  output logic              link_sync_n
);

  localparam int FRAME_W = DATA_W + 4;

  logic [FRAME_W-1:0] win;
  logic               frame_ok;
  logic               is_word;
  logic               has_flag;
  logic [DATA_W-1:0]  word;
  logic               par_bit;
  logic               slot;
  logic               take;

  deframe_window #(.FRAME_W(FRAME_W)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_in(rx_bit), .win(win)
  );

  deframe_decode #(.DATA_W(DATA_W)) u_dec (
    .win(win), .frame_ok(frame_ok), .is_word(is_word), .has_flag(has_flag),
    .word(word), .par_bit(par_bit)
  );

  deframe_sync #(.FRAME_W(FRAME_W), .SYNC_FRAMES(SYNC_FRAMES)) u_sync (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .slot(slot),
    .sync_n(link_sync_n), .err_n(link_err_n)
  );

  assign take = slot && frame_ok && is_word;

  deframe_word #(.DATA_W(DATA_W)) u_word (
    .clk(clk), .rst_n(rst_n), .take(take), .flag(has_flag), .word(word),
    .par(par_bit), .dout(rx_word), .par_out(rx_par), .flag_out(rx_flag_tgl),
    .wr_stb(rx_wr_stb)
  );

  AST_STB_ONLY_SYNCED: assert property (@(posedge clk) disable iff (!rst_n) rx_wr_stb |-> !link_sync_n); // R5
  AST_NO_STB_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n) !link_err_n |-> !rx_wr_stb); // R7

endmodule

// File: tb/tb_link_deframer.sv
module tb_link_deframer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NV         = 14;

  // entry: {kind[1:0], flag, inv, data[35:0]}; kind 0 word, 1 stuffing, 2 bad header, 3 bad parity
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 36'h123456789},
    {2'd0, 1'b0, 1'b1, 36'hFEDCBA987},
    {2'd1, 1'b0, 1'b0, 36'h000000000},
    {2'd0, 1'b1, 1'b0, 36'h00000000F},
    {2'd0, 1'b0, 1'b0, 36'hFFFFFFFFF},
    {2'd1, 1'b0, 1'b0, 36'h000000000},
    {2'd0, 1'b1, 1'b1, 36'hA5A5A5A5A},
    {2'd3, 1'b0, 1'b0, 36'h000000001},
    {2'd0, 1'b0, 1'b0, 36'h0F0F0F0F0},
    {2'd0, 1'b1, 1'b0, 36'h111111111},
    {2'd2, 1'b0, 1'b0, 36'h000000000},
    {2'd0, 1'b0, 1'b1, 36'h876543210},
    {2'd1, 1'b0, 1'b0, 36'h000000000},
    {2'd0, 1'b1, 1'b1, 36'h3C3C3C3C3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_bit = 1'b0;
  logic [35:0] rx_word;
  logic        rx_par, rx_flag_tgl, rx_wr_stb, link_err_n, link_sync_n;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_on = 1'b0;

  logic [35:0] ew_word [64];
  logic        ew_par  [64];
  logic        ew_flag [64];
  int          ew_cyc  [64];
  int          w_wr = 0, w_rd = 0;
  int          ee_cyc  [64];
  int          e_wr = 0, e_rd = 0;
  int          err_seen = 0;
  logic        flag_lvl = 1'b0;
  int          sync_chk_cyc = -1;
  logic        sync_chk_val = 1'b1;

  link_deframer dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_word(rx_word), .rx_par(rx_par),
    .rx_flag_tgl(rx_flag_tgl), .rx_wr_stb(rx_wr_stb), .link_err_n(link_err_n),
    .link_sync_n(link_sync_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [39:0] mk(input logic [39:0] v);
    logic [35:0] d;
    d = v[35:0];
    case (v[39:38])
      2'd0:    return {v[37] ? 2'b11 : 2'b10, v[36], ^d, v[36] ? ~d : d};
      2'd1:    return {2'b01, 2'b00, 36'h0};
      2'd2:    return 40'h0;
      default: return {2'b10, 1'b0, ~(^d), d};
    endcase
  endfunction

  task automatic send(input logic [39:0] v, input bit synced);
    logic [39:0] f;
    f = mk(v);
    for (int i = 39; i >= 0; i--) begin
      @(negedge clk);
      rx_bit = f[i];
    end
    if (synced && v[39:38] == 2'd0) begin
      if (v[37]) flag_lvl = ~flag_lvl;
      ew_word[w_wr] = v[35:0];
      ew_par[w_wr]  = ^v[35:0];
      ew_flag[w_wr] = flag_lvl;
      ew_cyc[w_wr]  = cyc + (v[37] ? 3 : 2);
      w_wr++;
    end
    if (synced && v[39:38] >= 2'd2) begin
      ee_cyc[e_wr] = cyc + 2;
      e_wr++;
    end
  endtask

  task automatic resync();
    for (int k = 0; k < 3; k++) send(40'h0 | {2'd2, 38'h0}, 1'b0);
    for (int k = 0; k < 6; k++) send({2'd1, 38'h0}, 1'b0);
    chk(link_sync_n == 1'b0, "R3", "relock after fault", {63'h0, link_sync_n}, 64'h0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (rx_wr_stb) begin
        if (w_rd == w_wr) begin
          chk(1'b0, "R5", "unexpected strobe", {28'h0, rx_word}, 64'h0);
        end else begin
          chk(cyc == ew_cyc[w_rd], ew_flag[w_rd] != (w_rd == 0 ? 1'b0 : ew_flag[w_rd-1]) ? "R9" : "R4",
              "strobe edge", 64'(cyc), 64'(ew_cyc[w_rd]));
          chk(rx_word == ew_word[w_rd], "R6", "word", {28'h0, rx_word}, {28'h0, ew_word[w_rd]});
          chk(rx_par == ew_par[w_rd], "R4", "parity out", {63'h0, rx_par}, {63'h0, ew_par[w_rd]});
          chk(rx_flag_tgl == ew_flag[w_rd], "R9", "flag level", {63'h0, rx_flag_tgl}, {63'h0, ew_flag[w_rd]});
          w_rd++;
        end
      end
      if (!link_err_n) begin
        err_seen++;
        if (e_rd == e_wr) begin
          chk(1'b0, "R10", "unexpected error pulse", 64'(cyc), 64'h0);
        end else begin
          chk(cyc == ee_cyc[e_rd], "R7", "error edge", 64'(cyc), 64'(ee_cyc[e_rd]));
          chk(link_sync_n == 1'b1, "R8", "sync released with error", {63'h0, link_sync_n}, 64'h1);
          e_rd++;
        end
      end
      if (cyc == sync_chk_cyc) begin
        chk(link_sync_n == sync_chk_val, "R3", "lock decision", {63'h0, link_sync_n}, {63'h0, sync_chk_val});
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", 64'(cyc), 64'(WATCHDOG));
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while held
    chk(link_sync_n == 1'b1, "R1", "sync in reset", {63'h0, link_sync_n}, 64'h1);
    chk(link_err_n == 1'b1, "R1", "err in reset", {63'h0, link_err_n}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_flag_tgl == 1'b0 && rx_wr_stb == 1'b0, "R1", "flag/strobe after reset",
        {62'h0, rx_flag_tgl, rx_wr_stb}, 64'h0);
    mon_on = 1'b1;
    repeat (10) @(negedge clk);
    // R3: lock after the fourth good frame, not before
    for (int k = 0; k < 3; k++) send({2'd1, 38'h0}, 1'b0);
    sync_chk_cyc = cyc + 2;
    sync_chk_val = 1'b1;
    send({2'd1, 38'h0}, 1'b0);
    sync_chk_cyc = cyc + 2;
    sync_chk_val = 1'b0;
    send({2'd1, 38'h0}, 1'b1);
    send({2'd1, 38'h0}, 1'b1);
    // table walk: R2 R4 R5 R6 R7 R8 R9 R11
    for (int n = 0; n < NV; n++) begin
      send(VEC[n], 1'b1);
      if (VEC[n][39:38] >= 2'd2) resync();
    end
    repeat (6) @(negedge clk);
    // R11: outputs hold with no strobe
    chk(rx_word == 36'h3C3C3C3C3, "R11", "word held", {28'h0, rx_word}, 64'h3C3C3C3C3);
    chk(w_rd == w_wr, "R4", "all words delivered", 64'(w_rd), 64'(w_wr));
    chk(e_rd == e_wr, "R7", "all faults reported", 64'(e_rd), 64'(e_wr));
    chk(err_seen == 2, "R10", "error pulse count", 64'(err_seen), 64'd2);
    finish_up();
  end

endmodule